// File: doc/BRIEF.md
# Periodic Wakeup Timer

This block raises a periodic wakeup interrupt by counting tick pulses from one of two tick sources. The slow internal source delivers one pulse per nominal millisecond. The external source is a tick derived from the chosen external clock. A single select bit picks which source is counted, and the other one is ignored. The ticks themselves are produced elsewhere. Each is a one-cycle enable in the block's clock domain, and a tick held high for several cycles counts once per cycle.

A 3-bit period code picks the interval. The divide ratio depends on both the code and the source. Code zero switches the timer off: the count is held at zero and no interrupt is raised. On expiry the count reloads to zero and a sticky interrupt flag is set. The flag stays set until software pulses the acknowledge input for one cycle. Any change of the period code or of the source select restarts the count from zero, so a new interval always starts from a clean count.

Top module: `wake_timer`

## Requirements
- R1: With period code 0 (`period_code == 3'b000`), the count is held at zero and the flag never sets, whichever source is selected and whatever ticks arrive.
- R2: With the internal source (`src_ext == 0`), codes 1 to 7 set the flag on exactly the 8th, 32nd, 64th, 128th, 256th, 512th and 1024th internal tick after a restart.
- R3: With the external source (`src_ext == 1`), codes 1 to 7 set the flag on exactly the 256th, 1024th, 2048th, 4096th, 8192nd, 16384th and 32768th external tick after a restart.
- R4: Ticks on the source that is not selected have no effect on the count or on the flag.
- R5: The flag is set in the clock edge that counts the expiring tick. It stays set until a cycle with `irq_ack` high, and then reads 0 from the next edge on.
- R6: When `irq_ack` and an expiring tick fall in the same cycle, the flag remains set.
- R7: A cycle whose period code or source select differs from the value in the previous cycle resets the count to zero. A tick in that same cycle is not counted.
- R8: Synchronous active-high reset clears the count and the flag.
- R9: After an expiry the count restarts at zero, so the next expiry comes one full period later. This holds whether or not the flag was acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| int_tick | input | 1 | Internal 1 ms tick enable |
| ext_tick | input | 1 | External clock-derived tick enable |
| src_ext | input | 1 | Source select: 0 internal, 1 external |
| period_code | input | 3 | Period select code, 0 turns the timer off |
| irq_ack | input | 1 | One-cycle flag acknowledge |
| irq_flag | output | 1 | Sticky wakeup interrupt flag |

## Verification
Two pairs of events can fall in the same cycle. The first is an acknowledge arriving in the cycle of an expiring tick. The second is a configuration change in a cycle whose selected tick is high. The bench provokes each one by raising the inputs together on the same falling edge. For the first pair it expects the flag to stay set. For the second it expects the count to discard the coincident tick, which makes the following expiry come exactly one full period after the change. A behavioural reference model, built from the period table, is compared with the flag on every cycle of the run. This catches an off-by-one in any of the fourteen divide ratios.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;

    localparam int CNT_W          = 15;
    localparam int CODE_W         = 3;
    localparam int INT_BASE_SHIFT = 3;
    localparam int EXT_BASE_SHIFT = 8;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } tick_src_e;

    typedef struct packed {
        tick_src_e          src;
        logic [CODE_W-1:0]  code;
    } wake_cfg_t;

    // Period code 1 is the base shift; code k >= 2 gives base + k.
    function automatic logic [CNT_W-1:0] last_count(wake_cfg_t c);
        int base;
        int sh;
        int tc;
        base = (c.src == SRC_EXT) ? EXT_BASE_SHIFT : INT_BASE_SHIFT;
        if (c.code == '0) begin
            return '0;
        end
        sh = (c.code == CODE_W'(1)) ? base : base + int'(c.code);
        tc = 1 << sh;
        return CNT_W'(tc - 1);
    endfunction

endpackage

// File: rtl/wt_tick_mux.sv
module wt_tick_mux
    import wake_timer_pkg::*;
(
    input  logic      int_tick,
    input  logic      ext_tick,
    input  tick_src_e src,
    output logic      tick
);
    always_comb begin
        unique case (src)
            SRC_EXT: tick = ext_tick;
            default: tick = int_tick;
        endcase
    end
endmodule

// File: rtl/wt_cfg_watch.sv
module wt_cfg_watch
    import wake_timer_pkg::*;
(
    input  logic             clk,
    input  wake_cfg_t        cfg,
    output logic             restart,
    output logic             enable,
    output logic [CNT_W-1:0] last
);
    wake_cfg_t cfg_q;

    // Tracks the input every cycle, reset included, so the first
    // cycle after reset compares against the value held in reset.
    always_ff @(posedge clk) begin
        cfg_q <= cfg;
    end

    always_comb begin
        restart = (cfg != cfg_q);
        enable  = (cfg.code != '0);
        last    = last_count(cfg);
    end
endmodule

// File: rtl/wt_counter.sv
module wt_counter
    import wake_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic             enable,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    always_comb begin
        expire = enable && !restart && tick && (count == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || restart) begin
            count <= '0;
        end else if (tick) begin
            count <= expire ? '0 : count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wt_flag.sv
module wt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wake_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                int_tick,
    input  logic                ext_tick,
    input  logic                src_ext,
    input  logic [CODE_W-1:0]   period_code,
    input  logic                irq_ack,
    output logic                irq_flag
);
    wake_cfg_t        cfg;
    logic             tick_sel;
    logic             restart;
    logic             enable;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] count_q;
    logic             expire;

    always_comb begin
        cfg.src  = tick_src_e'(src_ext);
        cfg.code = period_code;
    end

    wt_tick_mux u_mux (
        .int_tick (int_tick),
        .ext_tick (ext_tick),
        .src      (cfg.src),
        .tick     (tick_sel)
    );

    wt_cfg_watch u_cfg (
        .clk     (clk),
        .cfg     (cfg),
        .restart (restart),
        .enable  (enable),
        .last    (last)
    );

    wt_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_sel),
        .restart (restart),
        .enable  (enable),
        .last    (last),
        .count   (count_q),
        .expire  (expire)
    );

    wt_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (expire),
        .clr  (irq_ack),
        .flag (irq_flag)
    );
endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk
    import wake_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              int_tick,
    input logic              ext_tick,
    input logic              src_ext,
    input logic [CODE_W-1:0] period_code,
    input logic              irq_ack,
    input logic              irq_flag,
    input logic [CNT_W-1:0]  cnt
);
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!irq_flag && cnt == '0));

    assert_off_held_R1: assert property (@(posedge clk) disable iff (rst)
        (period_code == '0) |=> (cnt == '0));

    assert_off_no_flag_R1: assert property (@(posedge clk) disable iff (rst)
        (period_code == '0 && !irq_flag) |=> !irq_flag);

    assert_rise_reload_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_flag |=> (!irq_flag || cnt == '0));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (!irq_flag || cnt == '0));

    assert_cfg_restart_R7: assert property (@(posedge clk) disable iff (rst)
        ((period_code != $past(period_code)) || (src_ext != $past(src_ext)))
        |=> (cnt == '0));

    assert_unselected_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!(src_ext ? ext_tick : int_tick) && period_code != '0 &&
         period_code == $past(period_code) && src_ext == $past(src_ext))
        |=> $stable(cnt));
endmodule

bind wake_timer wake_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .int_tick    (int_tick),
    .ext_tick    (ext_tick),
    .src_ext     (src_ext),
    .period_code (period_code),
    .irq_ack     (irq_ack),
    .irq_flag    (irq_flag),
    .cnt         (count_q)
);

// File: tb/wake_timer_test.sv
`timescale 1ns/1ps
module wake_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       int_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic       src_ext = 1'b0;
    logic [2:0] period_code = 3'd0;
    logic       irq_ack = 1'b0;
    logic       irq_flag;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wake_timer uut (
        .clk         (clk),
        .rst         (rst),
        .int_tick    (int_tick),
        .ext_tick    (ext_tick),
        .src_ext     (src_ext),
        .period_code (period_code),
        .irq_ack     (irq_ack),
        .irq_flag    (irq_flag)
    );

    function automatic int period_of(bit ext, int code);
        int p_int[8] = '{0, 8, 32, 64, 128, 256, 512, 1024};
        int p_ext[8] = '{0, 256, 1024, 2048, 4096, 8192, 16384, 32768};
        return ext ? p_ext[code] : p_int[code];
    endfunction

    // Behavioural reference model
    int m_cnt = 0;
    bit m_flag = 1'b0;
    int p_code = 0;
    bit p_src = 1'b0;
    always @(posedge clk) begin
        bit hit;
        int per;
        hit = 1'b0;
        if (rst) begin
            m_cnt  = 0;
            m_flag = 1'b0;
        end else begin
            per = period_of(src_ext, int'(period_code));
            if (per == 0 || int'(period_code) != p_code || src_ext != p_src) begin
                m_cnt = 0;
            end else if (src_ext ? ext_tick : int_tick) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == per) begin
                    m_cnt = 0;
                    hit = 1'b1;
                end
            end
            if (hit) m_flag = 1'b1;
            else if (irq_ack) m_flag = 1'b0;
        end
        p_code = int'(period_code);
        p_src  = src_ext;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) check(irq_flag == m_flag, "R5 model compare", irq_flag, m_flag);
    end

    task automatic ticks(input bit ext, input int n);
        if (n > 0) begin
            @(negedge clk);
            if (ext) ext_tick = 1'b1; else int_tick = 1'b1;
            repeat (n) @(negedge clk);
            ext_tick = 1'b0;
            int_tick = 1'b0;
        end
    endtask

    task automatic set_cfg(input bit ext, input int code);
        @(negedge clk);
        src_ext     = ext;
        period_code = 3'(code);
        @(negedge clk);
    endtask

    task automatic ack;
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(irq_flag == 1'b0, "R8 reset flag", irq_flag, 0);
        rst = 1'b0;

        // R1: code zero with ticks on both sources
        set_cfg(1'b0, 0);
        @(negedge clk);
        int_tick = 1'b1; ext_tick = 1'b1;
        repeat (2000) @(negedge clk);
        int_tick = 1'b0; ext_tick = 1'b0;
        check(irq_flag == 1'b0, "R1 code zero internal", irq_flag, 0);
        set_cfg(1'b1, 0);
        ticks(1'b1, 40000);
        check(irq_flag == 1'b0, "R1 code zero external", irq_flag, 0);

        // R2 / R3: every code on both sources
        for (int s = 0; s < 2; s++) begin
            for (int c = 1; c < 8; c++) begin
                int per;
                per = period_of(s[0], c);
                set_cfg(s[0], c);
                ticks(s[0], per - 1);
                check(irq_flag == 1'b0, s ? "R3 before expiry" : "R2 before expiry", irq_flag, 0);
                ticks(s[0], 1);
                check(irq_flag == 1'b1, s ? "R3 at expiry" : "R2 at expiry", irq_flag, 1);
                ack();
                check(irq_flag == 1'b0, "R5 ack clears", irq_flag, 0);
                set_cfg(1'b0, 0);
            end
        end

        // R4: unselected source ignored
        set_cfg(1'b0, 1);
        ticks(1'b1, 50);
        check(irq_flag == 1'b0, "R4 external ignored", irq_flag, 0);
        ticks(1'b0, 8);
        check(irq_flag == 1'b1, "R4 internal counts 8", irq_flag, 1);

        // R9: next expiry a full period later without ack
        ticks(1'b0, 3);
        ack();
        ticks(1'b0, 4);
        check(irq_flag == 1'b0, "R9 mid period", irq_flag, 0);
        ticks(1'b0, 1);
        check(irq_flag == 1'b1, "R9 second expiry", irq_flag, 1);

        // R6: ack coincident with expiry
        ticks(1'b0, 7);
        @(negedge clk);
        int_tick = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        int_tick = 1'b0; irq_ack = 1'b0;
        check(irq_flag == 1'b1, "R6 expiry beats ack", irq_flag, 1);
        ack();
        check(irq_flag == 1'b0, "R5 ack after R6", irq_flag, 0);

        // R7: change with a coincident tick discards that tick
        ticks(1'b0, 5);
        @(negedge clk);
        period_code = 3'd2; int_tick = 1'b1;
        repeat (32) @(negedge clk);
        int_tick = 1'b0;
        check(irq_flag == 1'b0, "R7 restart after 31", irq_flag, 0);
        ticks(1'b0, 1);
        check(irq_flag == 1'b1, "R7 expiry at 32", irq_flag, 1);
        ack();
        ticks(1'b0, 20);
        set_cfg(1'b1, 2);
        set_cfg(1'b0, 2);
        ticks(1'b0, 31);
        check(irq_flag == 1'b0, "R7 source toggle restart", irq_flag, 0);
        ticks(1'b0, 1);
        check(irq_flag == 1'b1, "R7 source toggle expiry", irq_flag, 1);

        // R8: reset mid run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(irq_flag == 1'b0, "R8 reset clears flag", irq_flag, 0);
        rst = 1'b0;
        ticks(1'b0, 31);
        check(irq_flag == 1'b0, "R8 count cleared", irq_flag, 0);
        ticks(1'b0, 1);
        check(irq_flag == 1'b1, "R8 full period after reset", irq_flag, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule